// File: doc/BRIEF.md
# Timer Core with Software Event Generation

This block is a compact two-channel timer whose central feature is a write-only event register. Each bit of that register stands for one software-requested event. Writing a 1 to a bit fires that event on the same clock edge as the write, and the bit never holds state. The events are:

- a counter restart with a transfer of the buffered settings,
- a forced capture or compare on either channel,
- a commutation of the buffered output-control bits,
- a trigger flag,
- a break that drops the master output enable.

The timer also runs on its own. A prescaled up-counter wraps at a reload value and then raises the same update flag that a software restart raises. Sticky status flags feed one interrupt line and four DMA request lines through enable masks.

Software reaches every register over a simple synchronous bus. A write takes effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. Word addresses: 0x0 control, 0x1 channel direction, 0x2 buffered output control, 0x3 active output control (read only), 0x4 enables, 0x5 status, 0x6 event register, 0x7 counter, 0x8 buffered prescaler, 0x9 buffered reload, 0xA channel-1 value, 0xB channel-2 value, 0xC active prescaler (read only), 0xD active reload (read only).

Top module: `evtim_core`

## Requirements
- R1: The event register (0x6) fires events on written 1s at bits 0 (restart), 1 (channel 1), 2 (channel 2), 5 (commutation), 6 (trigger) and 7 (break). It always reads 0. Written 0s and writes to bits 3 and 4 change neither the status, nor the counter, nor the channel values.
- R2: A restart (0x6 bit 0) clears the counter and the prescale counter. It copies the buffered prescaler (0x8) and reload (0x9) values into the active copies (0xC, 0xD) and sets the update flag, status bit 0.
- R3: After reset the active and buffered reload values read 0xFFFF and every other register reads 0. With control bit 0 set, the counter advances once every (prescaler+1) clocks. On the clock after it equals the active reload value it wraps to 0, sets status bit 0 and loads the buffered values into the active copies.
- R4: A channel-event bit on a channel set as an output (0x1 bit i = 0) sets that channel's flag (status bit 1 or 2) and leaves its value register unchanged.
- R5: A channel-event bit on a channel set as an input (0x1 bit i = 1) stores the present counter value in that channel's value register and sets its flag.
- R6: A capture that finds the channel's flag already set also sets its overcapture flag (status bit 9 for channel 1, bit 10 for channel 2).
- R7: Output control is laid out as bit 0 output enable, bit 1 complementary enable, bits 4:2 mode. With control bit 1 set, writes to 0x2 stay buffered until a commutation event copies them to 0x3. With control bit 1 clear, writes to 0x2 go straight to 0x3 and a commutation event changes nothing.
- R8: A trigger event sets status bit 6.
- R9: A break event clears the master output enable (control bit 2, pin `moe_o`), sets status bit 7 and forces the channel-1 enable pins low.
- R10: Writing 0x5 clears every flag written as 0 and keeps every flag written as 1. A flag set by hardware on the same edge as a clear stays set.
- R11: `irq_o` is high while any status bit 0, 1, 2, 6 or 7 is set together with the same bit in 0x4. `dma_req_o[3:0]` reflects status bits {6,2,1,0} masked by 0x4 bits {14,10,9,8}.
- R12: Several event bits written together all take effect on the same edge. A capture in that write sees the counter value from before the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq_o | output | 1 | Combined interrupt request |
| dma_req_o | output | 4 | DMA requests {trigger, ch2, ch1, update} |
| moe_o | output | 1 | Master output enable |
| ch1_oe_o | output | 1 | Channel-1 output enable, gated by `moe_o` |
| ch1_oen_o | output | 1 | Channel-1 complementary enable, gated by `moe_o` |
| ch1_mode_o | output | 3 | Active channel-1 output mode |

## Verification
Every state element can be read back on the bus, so a wrong flag, captured value or active copy shows at `bus_rdata` on the first read after the edge that caused it. A bad prescale or wrap count shows up differently. It appears only as the counter reaching its reload value, or raising its update flag, on the wrong clock, so the bench samples the counter one clock before and one clock after the expected wrap. A wrong break or commutation path shows at once on the channel-1 enable pins and on `moe_o`. Wrong enable masking shows on `irq_o` and `dma_req_o` with no clock of delay.

// File: rtl/evtim_pkg.sv
package evtim_pkg;

    // Register word addresses
    localparam logic [3:0] A_CTRL    = 4'h0;
    localparam logic [3:0] A_CHMODE  = 4'h1;
    localparam logic [3:0] A_OCPRE   = 4'h2;
    localparam logic [3:0] A_OCACT   = 4'h3;
    localparam logic [3:0] A_IEN     = 4'h4;
    localparam logic [3:0] A_STAT    = 4'h5;
    localparam logic [3:0] A_EVGEN   = 4'h6;
    localparam logic [3:0] A_CNT     = 4'h7;
    localparam logic [3:0] A_PSC     = 4'h8;
    localparam logic [3:0] A_ARR     = 4'h9;
    localparam logic [3:0] A_CCR1    = 4'hA;
    localparam logic [3:0] A_PSC_ACT = 4'hC;
    localparam logic [3:0] A_ARR_ACT = 4'hD;

    // Event register bit positions
    localparam int EV_UG  = 0;
    localparam int EV_CC1 = 1;
    localparam int EV_COM = 5;
    localparam int EV_TG  = 6;
    localparam int EV_BG  = 7;

    // Status bit positions
    localparam int F_U   = 0;
    localparam int F_CC1 = 1;
    localparam int F_T   = 6;
    localparam int F_B   = 7;
    localparam int F_OF1 = 9;

    // Enable register: DMA enables sit this far above the interrupt enables
    localparam int DMA_OFS = 8;

    // Control register bit positions
    localparam int C_RUN = 0;
    localparam int C_PRE = 1;
    localparam int C_MOE = 2;

    typedef struct packed {
        logic [2:0] mode;
        logic       oen;
        logic       oe;
    } ocfg_t;

endpackage

// File: rtl/evtim_timebase.sv
module evtim_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             ug_i,
    input  logic             cnt_wr_i,
    input  logic             psc_wr_i,
    input  logic             arr_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] psc_pre_o,
    output logic [CNT_W-1:0] arr_pre_o,
    output logic [CNT_W-1:0] psc_act_o,
    output logic [CNT_W-1:0] arr_act_o,
    output logic             ovf_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] pc;
        logic [CNT_W-1:0] psc_pre;
        logic [CNT_W-1:0] arr_pre;
        logic [CNT_W-1:0] psc_act;
        logic [CNT_W-1:0] arr_act;
    } tb_state_t;

    tb_state_t q, d;
    logic      tick;
    logic      ovf;

    always_comb begin
        d    = q;
        tick = 1'b0;
        ovf  = 1'b0;
        // prescale divider
        if (run_i) begin
            if (q.pc == q.psc_act) begin
                d.pc = '0;
                tick = 1'b1;
            end else begin
                d.pc = q.pc + 1'b1;
            end
        end
        // main counter step and natural wrap
        if (tick) begin
            if (q.cnt == q.arr_act) begin
                ovf   = 1'b1;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        if (psc_wr_i) d.psc_pre = wdata_i;
        if (arr_wr_i) d.arr_pre = wdata_i;
        if (cnt_wr_i) d.cnt     = wdata_i;
        // shadow transfer on any update
        if (ovf || ug_i) begin
            d.psc_act = q.psc_pre;
            d.arr_act = q.arr_pre;
        end
        // software restart overrides every other counter source
        if (ug_i) begin
            d.cnt = '0;
            d.pc  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cnt     <= '0;
            q.pc      <= '0;
            q.psc_pre <= '0;
            q.psc_act <= '0;
            q.arr_pre <= '1;
            q.arr_act <= '1;
        end else begin
            q <= d;
        end
    end

    assign cnt_o     = q.cnt;
    assign psc_pre_o = q.psc_pre;
    assign arr_pre_o = q.arr_pre;
    assign psc_act_o = q.psc_act;
    assign arr_act_o = q.arr_act;
    assign ovf_o     = ovf;

endmodule

// File: rtl/evtim_chan.sv
module evtim_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_input_i,
    input  logic             gen_i,
    input  logic             flag_i,
    input  logic             ccr_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] ccr_o,
    output logic             set_if_o,
    output logic             set_of_o
);

    typedef struct packed {
        logic [CNT_W-1:0] ccr;
    } ch_state_t;

    ch_state_t q, d;

    always_comb begin
        d        = q;
        set_if_o = gen_i;
        set_of_o = gen_i && is_input_i && flag_i;
        if (ccr_wr_i) d.ccr = wdata_i;
        if (gen_i && is_input_i) d.ccr = cnt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ccr <= '0;
        end else begin
            q <= d;
        end
    end

    assign ccr_o = q.ccr;

endmodule

// File: rtl/evtim_outctl.sv
module evtim_outctl
    import evtim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr_i,
    input  logic [2:0] ctrl_bits_i,
    input  logic       ocpre_wr_i,
    input  ocfg_t      ocpre_i,
    input  logic       com_i,
    input  logic       brk_i,
    output logic       run_o,
    output logic       ccpc_o,
    output logic       moe_o,
    output ocfg_t      oc_pre_o,
    output ocfg_t      oc_act_o
);

    typedef struct packed {
        logic  run;
        logic  ccpc;
        logic  moe;
        ocfg_t pre;
        ocfg_t act;
    } oc_state_t;

    oc_state_t q, d;

    always_comb begin
        d = q;
        if (ctrl_wr_i) begin
            d.run  = ctrl_bits_i[C_RUN];
            d.ccpc = ctrl_bits_i[C_PRE];
            d.moe  = ctrl_bits_i[C_MOE];
        end
        if (ocpre_wr_i) begin
            d.pre = ocpre_i;
            if (!q.ccpc) d.act = ocpre_i;
        end
        if (com_i && q.ccpc) d.act = q.pre;
        if (brk_i) d.moe = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign run_o    = q.run;
    assign ccpc_o   = q.ccpc;
    assign moe_o    = q.moe;
    assign oc_pre_o = q.pre;
    assign oc_act_o = q.act;

endmodule

// File: rtl/evtim_core.sv
module evtim_core
    import evtim_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic [3:0]        dma_req_o,
    output logic              moe_o,
    output logic              ch1_oe_o,
    output logic              ch1_oen_o,
    output logic [2:0]        ch1_mode_o
);

    localparam int EV_W = EV_BG + 1;
    localparam int IRQ_W = F_B + 1;
    localparam logic [DATA_W-1:0] CH_FLAGS = DATA_W'(((1 << NUM_CH) - 1) << F_CC1);
    localparam logic [DATA_W-1:0] OF_FLAGS = DATA_W'(((1 << NUM_CH) - 1) << F_OF1);
    localparam logic [DATA_W-1:0] FLAG_MASK =
        DATA_W'((1 << F_U) | (1 << F_T) | (1 << F_B)) | CH_FLAGS | OF_FLAGS;
    localparam logic [DATA_W-1:0] IRQ_MASK =
        DATA_W'((1 << F_U) | (1 << F_T) | (1 << F_B)) | CH_FLAGS;
    localparam logic [DATA_W-1:0] IEN_MASK = IRQ_MASK | (IRQ_MASK << DMA_OFS);

    typedef struct packed {
        logic [NUM_CH-1:0] chmode;
        logic [DATA_W-1:0] ien;
        logic [DATA_W-1:0] flags;
    } core_state_t;

    core_state_t q, d;

    logic [EV_W-1:0]   ev;
    logic [DATA_W-1:0] set_vec;
    logic              ovf;
    logic [CNT_W-1:0]  cnt_w, psc_pre_w, arr_pre_w, psc_act_w, arr_act_w;
    logic              run_w, ccpc_w;
    ocfg_t             oc_pre_w, oc_act_w;
    logic [CNT_W-1:0]  ccr_w    [NUM_CH];
    logic [NUM_CH-1:0] set_if_w;
    logic [NUM_CH-1:0] set_of_w;

    // signals brought out for the bound checker
    logic [DATA_W-1:0] flags_w;
    logic [4:0]        ocact_w;

    function automatic logic hit(input logic [3:0] a);
        return bus_wr && (bus_addr == a);
    endfunction

    assign ev = hit(A_EVGEN) ? bus_wdata[EV_W-1:0] : '0;

    evtim_timebase #(.CNT_W(CNT_W)) tbase_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_w),
        .ug_i      (ev[EV_UG]),
        .cnt_wr_i  (hit(A_CNT)),
        .psc_wr_i  (hit(A_PSC)),
        .arr_wr_i  (hit(A_ARR)),
        .wdata_i   (bus_wdata[CNT_W-1:0]),
        .cnt_o     (cnt_w),
        .psc_pre_o (psc_pre_w),
        .arr_pre_o (arr_pre_w),
        .psc_act_o (psc_act_w),
        .arr_act_o (arr_act_w),
        .ovf_o     (ovf)
    );

    evtim_outctl octl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr_i   (hit(A_CTRL)),
        .ctrl_bits_i (bus_wdata[2:0]),
        .ocpre_wr_i  (hit(A_OCPRE)),
        .ocpre_i     (bus_wdata[4:0]),
        .com_i       (ev[EV_COM]),
        .brk_i       (ev[EV_BG]),
        .run_o       (run_w),
        .ccpc_o      (ccpc_w),
        .moe_o       (moe_o),
        .oc_pre_o    (oc_pre_w),
        .oc_act_o    (oc_act_w)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            evtim_chan #(.CNT_W(CNT_W)) chan_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .is_input_i (q.chmode[i]),
                .gen_i      (ev[EV_CC1 + i]),
                .flag_i     (q.flags[F_CC1 + i]),
                .ccr_wr_i   (hit(A_CCR1 + 4'(i))),
                .wdata_i    (bus_wdata[CNT_W-1:0]),
                .cnt_i      (cnt_w),
                .ccr_o      (ccr_w[i]),
                .set_if_o   (set_if_w[i]),
                .set_of_o   (set_of_w[i])
            );
        end
    endgenerate

    always_comb begin
        set_vec        = '0;
        set_vec[F_U]   = ovf || ev[EV_UG];
        set_vec[F_T]   = ev[EV_TG];
        set_vec[F_B]   = ev[EV_BG];
        for (int i = 0; i < NUM_CH; i++) begin
            set_vec[F_CC1 + i] = set_if_w[i];
            set_vec[F_OF1 + i] = set_of_w[i];
        end
    end

    always_comb begin
        d = q;
        if (hit(A_CHMODE)) d.chmode = bus_wdata[NUM_CH-1:0];
        if (hit(A_IEN))    d.ien    = bus_wdata & IEN_MASK;
        // clear by writing 0; a same-edge hardware set wins
        d.flags = ((hit(A_STAT) ? (q.flags & bus_wdata) : q.flags) | set_vec) & FLAG_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:    bus_rdata = DATA_W'({moe_o, ccpc_w, run_w});
            A_CHMODE:  bus_rdata = DATA_W'(q.chmode);
            A_OCPRE:   bus_rdata = DATA_W'(oc_pre_w);
            A_OCACT:   bus_rdata = DATA_W'(oc_act_w);
            A_IEN:     bus_rdata = q.ien;
            A_STAT:    bus_rdata = q.flags;
            A_CNT:     bus_rdata = DATA_W'(cnt_w);
            A_PSC:     bus_rdata = DATA_W'(psc_pre_w);
            A_ARR:     bus_rdata = DATA_W'(arr_pre_w);
            A_PSC_ACT: bus_rdata = DATA_W'(psc_act_w);
            A_ARR_ACT: bus_rdata = DATA_W'(arr_act_w);
            default:   bus_rdata = '0;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == A_CCR1 + 4'(i)) bus_rdata = DATA_W'(ccr_w[i]);
        end
    end

    assign irq_o = |(q.flags[IRQ_W-1:0] & q.ien[IRQ_W-1:0]);

    always_comb begin
        dma_req_o    = '0;
        dma_req_o[0] = q.flags[F_U] && q.ien[F_U + DMA_OFS];
        dma_req_o[1] = q.flags[F_CC1] && q.ien[F_CC1 + DMA_OFS];
        dma_req_o[2] = q.flags[F_CC1 + 1] && q.ien[F_CC1 + 1 + DMA_OFS];
        dma_req_o[3] = q.flags[F_T] && q.ien[F_T + DMA_OFS];
    end

    assign ch1_oe_o   = moe_o && oc_act_w.oe;
    assign ch1_oen_o  = moe_o && oc_act_w.oen;
    assign ch1_mode_o = oc_act_w.mode;

    assign flags_w = q.flags;
    assign ocact_w = oc_act_w;

endmodule

// File: rtl/evtim_core_chk.sv
module evtim_core_chk
    import evtim_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [3:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              moe_o,
    input logic [CNT_W-1:0]  cnt,
    input logic [DATA_W-1:0] flags,
    input logic [4:0]        ocact,
    input logic              ccpc
);

    logic ev_wr;
    assign ev_wr = bus_wr && (bus_addr == A_EVGEN);

    AST_EVGEN_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_EVGEN) |-> (bus_rdata == '0)); // R1

    AST_UG_ZEROES_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wr && bus_wdata[EV_UG]) |=> (cnt == '0)); // R2

    AST_UG_SETS_UIF: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wr && bus_wdata[EV_UG]) |=> flags[F_U]); // R2

    AST_COM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wr && bus_wdata[EV_COM] && !ccpc) |=> $stable(ocact)); // R7

    AST_TG_SETS_TIF: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wr && bus_wdata[EV_TG]) |=> flags[F_T]); // R8

    AST_BG_DROPS_MOE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wr && bus_wdata[EV_BG]) |=> (!moe_o && flags[F_B])); // R9

endmodule

bind evtim_core evtim_core_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .moe_o     (moe_o),
    .cnt       (cnt_w),
    .flags     (flags_w),
    .ocact     (ocact_w),
    .ccpc      (ccpc_w)
);

// File: tb/evtim_core_tb.sv
module evtim_core_tb_top;
    import evtim_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o, moe_o, ch1_oe_o, ch1_oen_o;
    logic [3:0]  dma_req_o;
    logic [2:0]  ch1_mode_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    evtim_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_o      (irq_o),
        .dma_req_o  (dma_req_o),
        .moe_o      (moe_o),
        .ch1_oe_o   (ch1_oe_o),
        .ch1_oen_o  (ch1_oen_o),
        .ch1_mode_o (ch1_mode_o)
    );

    // {wr, waddr, wdata, raddr, expected, requirement number}
    localparam int NV = 38;
    localparam logic [44:0] VEC [NV] = '{
        {1'b1, 4'h7, 16'h0055, 4'h7, 16'h0055, 4'd5},  // R5 preset counter
        {1'b1, 4'h1, 16'h0001, 4'h1, 16'h0001, 4'd5},  // R5 ch1 input
        {1'b1, 4'h6, 16'h0002, 4'hA, 16'h0055, 4'd5},  // R5 capture
        {1'b0, 4'h0, 16'h0000, 4'h5, 16'h0002, 4'd5},  // R5 flag
        {1'b1, 4'h7, 16'h0077, 4'h7, 16'h0077, 4'd6},  // R6
        {1'b1, 4'h6, 16'h0002, 4'h5, 16'h0202, 4'd6},  // R6 overcapture
        {1'b0, 4'h0, 16'h0000, 4'hA, 16'h0077, 4'd6},  // R6
        {1'b1, 4'h5, 16'h0000, 4'h5, 16'h0000, 4'd10}, // R10 clear all
        {1'b1, 4'hB, 16'h1234, 4'hB, 16'h1234, 4'd4},  // R4
        {1'b1, 4'h6, 16'h0004, 4'h5, 16'h0004, 4'd4},  // R4 output event
        {1'b0, 4'h0, 16'h0000, 4'hB, 16'h1234, 4'd4},  // R4 value kept
        {1'b1, 4'h6, 16'h0018, 4'h5, 16'h0004, 4'd1},  // R1 unused bits
        {1'b0, 4'h0, 16'h0000, 4'h7, 16'h0077, 4'd1},  // R1
        {1'b1, 4'h6, 16'h0000, 4'hA, 16'h0077, 4'd1},  // R1 zero write
        {1'b1, 4'h5, 16'hFFFB, 4'h5, 16'h0000, 4'd10}, // R10 selective
        {1'b1, 4'h8, 16'h0003, 4'hC, 16'h0000, 4'd2},  // R2 buffered only
        {1'b1, 4'h9, 16'h0009, 4'hD, 16'hFFFF, 4'd2},  // R2
        {1'b1, 4'h6, 16'h0001, 4'h7, 16'h0000, 4'd2},  // R2 restart
        {1'b0, 4'h0, 16'h0000, 4'hC, 16'h0003, 4'd2},  // R2
        {1'b0, 4'h0, 16'h0000, 4'hD, 16'h0009, 4'd2},  // R2
        {1'b0, 4'h0, 16'h0000, 4'h5, 16'h0001, 4'd2},  // R2 update flag
        {1'b1, 4'h0, 16'h0006, 4'h0, 16'h0006, 4'd7},  // R7 preload on
        {1'b1, 4'h2, 16'h001F, 4'h3, 16'h0000, 4'd7},  // R7 held
        {1'b1, 4'h6, 16'h0020, 4'h3, 16'h001F, 4'd7},  // R7 commutation
        {1'b1, 4'h2, 16'h000A, 4'h2, 16'h000A, 4'd7},  // R7
        {1'b1, 4'h0, 16'h0004, 4'h3, 16'h001F, 4'd7},  // R7 preload off
        {1'b1, 4'h6, 16'h0020, 4'h3, 16'h001F, 4'd7},  // R7 gated
        {1'b1, 4'h2, 16'h0005, 4'h3, 16'h0005, 4'd7},  // R7 direct
        {1'b1, 4'h6, 16'h0040, 4'h5, 16'h0041, 4'd8},  // R8
        {1'b1, 4'h6, 16'h0080, 4'h0, 16'h0000, 4'd9},  // R9
        {1'b0, 4'h0, 16'h0000, 4'h5, 16'h00C1, 4'd9},  // R9
        {1'b1, 4'h5, 16'h0000, 4'h5, 16'h0000, 4'd10}, // R10
        {1'b1, 4'h7, 16'h0030, 4'h7, 16'h0030, 4'd12}, // R12
        {1'b1, 4'h6, 16'h00E7, 4'h5, 16'h00C7, 4'd12}, // R12 all at once
        {1'b0, 4'h0, 16'h0000, 4'hA, 16'h0030, 4'd12}, // R12 old count
        {1'b0, 4'h0, 16'h0000, 4'h7, 16'h0000, 4'd12}, // R12
        {1'b0, 4'h0, 16'h0000, 4'h6, 16'h0000, 4'd1},  // R1 reads zero
        {1'b1, 4'h0, 16'h0004, 4'h0, 16'h0004, 4'd9}   // R9 re-enable
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] dv);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = dv;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [3:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // reset state: R3
        read_check("R3 reset reload", A_ARR_ACT, 16'hFFFF);
        read_check("R3 reset status", A_STAT, 16'h0000);
        read_check("R3 reset control", A_CTRL, 16'h0000);
        check("R3 reset irq/moe", {14'd0, irq_o, moe_o}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [44:0] v;
            v = VEC[i];
            if (v[44]) bus_write(v[43:40], v[39:24]);
            else @(negedge clk);
            read_check($sformatf("vector %0d R%0d", i, v[3:0]), v[23:20], v[19:4]);
        end

        // channel-1 pins with master enable on and active control 0x05: R9
        check("R9 pins enabled", {11'd0, ch1_oe_o, ch1_oen_o, ch1_mode_o},
              {11'd0, 1'b1, 1'b0, 3'd1});
        bus_write(A_EVGEN, 16'h0080);
        #1;
        check("R9 pins after break", {14'd0, moe_o, ch1_oe_o}, 16'h0000);

        // free running with prescaler 3, reload 9: R3
        bus_write(A_EVGEN, 16'h0001);
        bus_write(A_STAT, 16'h0000);
        bus_write(A_CTRL, 16'h0001);
        repeat (39) @(posedge clk);
        @(negedge clk);
        read_check("R3 count before wrap", A_CNT, 16'h0009);
        read_check("R3 no flag before wrap", A_STAT, 16'h0000);
        @(posedge clk);
        @(negedge clk);
        read_check("R3 count wraps", A_CNT, 16'h0000);
        read_check("R3 update flag on wrap", A_STAT, 16'h0001);

        // clear on the same edge as the next wrap: R10
        repeat (39) @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = A_STAT;
        bus_wdata = 16'h0000;
        @(negedge clk);
        bus_wr = 1'b0;
        read_check("R10 set wins over clear", A_STAT, 16'h0001);
        read_check("R3 second wrap", A_CNT, 16'h0000);

        bus_write(A_CTRL, 16'h0000);
        bus_write(A_STAT, 16'h0000);

        // interrupt and DMA masking: R11
        bus_write(A_EVGEN, 16'h0040);
        #1;
        check("R11 no enable", {12'd0, irq_o, dma_req_o[2:0]}, 16'h0000);
        bus_write(A_IEN, 16'h0040);
        #1;
        check("R11 trigger irq", {11'd0, irq_o, dma_req_o}, 16'h0010);
        bus_write(A_IEN, 16'h4000);
        #1;
        check("R11 trigger dma", {11'd0, irq_o, dma_req_o}, 16'h0008);
        bus_write(A_IEN, 16'h0002);
        #1;
        check("R11 other source masked", {11'd0, irq_o, dma_req_o}, 16'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule